// File: doc/BRIEF.md
# Flash Embedded-Operation Status Reporter

This block produces the data byte that a byte-wide parallel NOR flash returns on its bus while an internal program or erase is under way. The operating mode is given on an input: plain read, byte program, sector erase, erase suspended with reads, or erase suspended with a program running. Other inputs describe the current read address, the sector that is being erased or is suspended, and the address and most significant data bit of the byte being programmed. On a status read the block drives three status bits. Bit 7 shows data polling. Bits 6 and 2 are two toggle bits that invert on successive reads under different rules. Together they let a host tell an active erase apart from a suspended one, and they show which sector is affected. Any read to which no status rule applies returns the array byte given on `array_data`.

The block also qualifies bus write cycles from the active-low chip-enable, write-enable and output-enable pins. A low-supply lockout flag blocks every write and forces the block back to plain read mode. The block samples all pins synchronously on `clk`. A read is complete when `oe_n` rises while `ce_n` is low. That completed read is the event that advances the toggle bits.

Top module: `flash_status_reporter`

## Requirements
- R1: After reset, `op_mode` is 0 (plain read), `dq_out` equals `array_data`, `write_en` is 0, and both toggle bits start at 0.
- R2: Mode codes are 0 read, 1 program, 2 erase, 3 suspended-read and 4 suspended-program. Codes 5 to 7 act as plain read and make `op_mode` report 0. In plain read, `dq_out` equals `array_data` and no toggle bit advances.
- R3: In program mode, every read at any address is a status read. It returns bit 7 = NOT `prog_data_b7`, bit 6 = the bit-6 toggle, bit 2 = 1, and 0 in bits 5:3 and 1:0. Every completed read inverts the bit-6 toggle.
- R4: In erase mode, a read whose sector (the top SECT_W address bits) equals `busy_sector` returns bit 7 = 0, bit 6 = the bit-6 toggle and bit 2 = the bit-2 toggle. All other bits are 0. Each completed read of that kind inverts both toggles.
- R5: In erase mode, a read outside the busy sector returns `array_data` and leaves both toggles unchanged.
- R6: In suspended-read mode, a read of the suspended sector returns bit 7 = 1, bit 6 = 1 and bit 2 = the bit-2 toggle, with the other bits 0. Only the bit-2 toggle inverts.
- R7: In suspended-read mode, a read outside the suspended sector returns `array_data` and advances no toggle.
- R8: In suspended-program mode, a read at `prog_addr` returns bit 7 = NOT `prog_data_b7`, bit 6 = the bit-6 toggle and bit 2 = 1, and inverts only the bit-6 toggle. A read of the suspended sector at any other address behaves as in R6. Any other address returns `array_data`.
- R9: A change of mode appears on `op_mode` one clock after the inputs change. It clears both toggle bits, so the first status read in the new mode shows 0 in every toggling bit.
- R10: A read completes only on a rising `oe_n` that the clock samples while `ce_n` is low. A rising `oe_n` with `ce_n` high advances no toggle.
- R11: `write_en` is 1 only when `ce_n` is 0, `we_n` is 0, `oe_n` is 1 and `lockout` is 0.
- R12: `write_start` is a one-clock pulse in the first cycle of each `write_en` interval.
- R13: While `lockout` is 1, `op_mode` is forced to 0 from the next clock, the toggles clear and writes are refused. Once the flag drops, the requested mode returns one clock later with both toggles at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lockout | input | 1 | Low-supply lockout flag |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| mode_sel | input | 3 | Requested operating mode code |
| rd_addr | input | ADDR_W | Address of the current read |
| busy_sector | input | SECT_W | Sector being erased or suspended |
| prog_addr | input | ADDR_W | Address of the byte being programmed |
| prog_data_b7 | input | 1 | Bit 7 of the byte being programmed |
| array_data | input | 8 | Array contents at `rd_addr` |
| dq_out | output | 8 | Byte returned on the bus |
| write_en | output | 1 | Qualified write cycle in progress |
| write_start | output | 1 | First cycle of a qualified write |
| op_mode | output | 3 | Effective operating mode |

## Verification
The assertions check on every cycle the rules that need only the current pins and `op_mode`. They cover write qualification and its refusal under lockout, the single-cycle write pulse, the forced return to read mode, the legal range of `op_mode`, the constant status bits of each mode and the pass-through in read mode. Only the bench can show the toggle sequences. It checks that the bits alternate across back-to-back reads, that they restart at 0 on every mode entry, and that reads outside the affected sector or with chip enable high leave the sequence where it was. A bench model tracks the toggles and follows long random runs of mode changes, lockouts and mixed addresses.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [2:0] {
        OPM_READ    = 3'd0,
        OPM_PROG    = 3'd1,
        OPM_ERASE   = 3'd2,
        OPM_SUSP_RD = 3'd3,
        OPM_SUSP_PG = 3'd4
    } opmode_e;

    localparam int BYTE_W   = 8;
    localparam int POLL_BIT = 7;
    localparam int TOG6_BIT = 6;
    localparam int TOG2_BIT = 2;

    typedef struct packed {
        opmode_e mode;
        logic    tog6;
        logic    tog2;
    } core_state_t;

    typedef struct packed {
        logic oe_n_prev;
        logic wr_prev;
    } bus_state_t;

    function automatic opmode_e legal_mode(input logic [2:0] code);
        opmode_e m;
        case (code)
            3'd1:    m = OPM_PROG;
            3'd2:    m = OPM_ERASE;
            3'd3:    m = OPM_SUSP_RD;
            3'd4:    m = OPM_SUSP_PG;
            default: m = OPM_READ;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fsr_bus_qual.sv
module fsr_bus_qual
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lockout,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic rd_strobe,
    output logic write_en,
    output logic write_start
);

    bus_state_t bus_d, bus_q;
    logic       wr_qual;

    always_comb begin
        wr_qual         = !ce_n && !we_n && oe_n && !lockout;
        bus_d           = bus_q;
        bus_d.oe_n_prev = oe_n;
        bus_d.wr_prev   = wr_qual;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q.oe_n_prev <= 1'b1;
            bus_q.wr_prev   <= 1'b0;
        end else begin
            bus_q <= bus_d;
        end
    end

    assign rd_strobe   = !bus_q.oe_n_prev && oe_n && !ce_n;
    assign write_en    = wr_qual;
    assign write_start = wr_qual && !bus_q.wr_prev;

endmodule

// File: rtl/fsr_addr_decode.sv
module fsr_addr_decode #(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [SECT_W-1:0] busy_sector,
    input  logic [ADDR_W-1:0] prog_addr,
    output logic              in_busy,
    output logic              at_prog
);

    localparam int SECT_LSB = ADDR_W - SECT_W;

    logic [SECT_W-1:0] rd_sector;

    always_comb begin
        rd_sector = rd_addr[ADDR_W-1:SECT_LSB];
        in_busy   = (rd_sector == busy_sector);
        at_prog   = (rd_addr == prog_addr);
    end

endmodule

// File: rtl/fsr_status_mux.sv
module fsr_status_mux
    import fsr_pkg::*;
(
    input  opmode_e           mode,
    input  logic              in_busy,
    input  logic              at_prog,
    input  logic              tog6,
    input  logic              tog2,
    input  logic              prog_data_b7,
    input  logic [BYTE_W-1:0] array_data,
    output logic [BYTE_W-1:0] dq,
    output logic              flip6,
    output logic              flip2
);

    logic              is_status;
    logic              b_poll;
    logic              b_six;
    logic              b_two;
    logic [BYTE_W-1:0] status_byte;

    always_comb begin
        is_status = 1'b0;
        b_poll    = 1'b0;
        b_six     = 1'b0;
        b_two     = 1'b0;
        flip6     = 1'b0;
        flip2     = 1'b0;
        case (mode)
            OPM_PROG: begin
                is_status = 1'b1;
                b_poll    = !prog_data_b7;
                b_six     = tog6;
                b_two     = 1'b1;
                flip6     = 1'b1;
            end
            OPM_ERASE: begin
                if (in_busy) begin
                    is_status = 1'b1;
                    b_poll    = 1'b0;
                    b_six     = tog6;
                    b_two     = tog2;
                    flip6     = 1'b1;
                    flip2     = 1'b1;
                end
            end
            OPM_SUSP_RD: begin
                if (in_busy) begin
                    is_status = 1'b1;
                    b_poll    = 1'b1;
                    b_six     = 1'b1;
                    b_two     = tog2;
                    flip2     = 1'b1;
                end
            end
            OPM_SUSP_PG: begin
                if (at_prog) begin
                    is_status = 1'b1;
                    b_poll    = !prog_data_b7;
                    b_six     = tog6;
                    b_two     = 1'b1;
                    flip6     = 1'b1;
                end else if (in_busy) begin
                    is_status = 1'b1;
                    b_poll    = 1'b1;
                    b_six     = 1'b1;
                    b_two     = tog2;
                    flip2     = 1'b1;
                end
            end
            default: begin
                is_status = 1'b0;
            end
        endcase

        status_byte           = '0;
        status_byte[POLL_BIT] = b_poll;
        status_byte[TOG6_BIT] = b_six;
        status_byte[TOG2_BIT] = b_two;
        dq = is_status ? status_byte : array_data;
    end

endmodule

// File: rtl/flash_status_reporter.sv
module flash_status_reporter
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lockout,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [2:0]        mode_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [SECT_W-1:0] busy_sector,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic              prog_data_b7,
    input  logic [7:0]        array_data,
    output logic [7:0]        dq_out,
    output logic              write_en,
    output logic              write_start,
    output logic [2:0]        op_mode
);

    core_state_t st_d, st_q;
    logic        rd_strobe;
    logic        in_busy;
    logic        at_prog;
    logic        flip6;
    logic        flip2;

    fsr_bus_qual u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .lockout     (lockout),
        .ce_n        (ce_n),
        .we_n        (we_n),
        .oe_n        (oe_n),
        .rd_strobe   (rd_strobe),
        .write_en    (write_en),
        .write_start (write_start)
    );

    fsr_addr_decode #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W)
    ) u_dec (
        .rd_addr     (rd_addr),
        .busy_sector (busy_sector),
        .prog_addr   (prog_addr),
        .in_busy     (in_busy),
        .at_prog     (at_prog)
    );

    fsr_status_mux u_mux (
        .mode         (st_q.mode),
        .in_busy      (in_busy),
        .at_prog      (at_prog),
        .tog6         (st_q.tog6),
        .tog2         (st_q.tog2),
        .prog_data_b7 (prog_data_b7),
        .array_data   (array_data),
        .dq           (dq_out),
        .flip6        (flip6),
        .flip2        (flip2)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mode = lockout ? OPM_READ : legal_mode(mode_sel);
        if (st_d.mode != st_q.mode) begin
            st_d.tog6 = 1'b0;
            st_d.tog2 = 1'b0;
        end else if (rd_strobe) begin
            st_d.tog6 = st_q.tog6 ^ flip6;
            st_d.tog2 = st_q.tog2 ^ flip2;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= OPM_READ;
            st_q.tog6 <= 1'b0;
            st_q.tog2 <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign op_mode = st_q.mode;

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lockout,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [SECT_W-1:0] busy_sector,
    input logic [7:0]        array_data,
    input logic [7:0]        dq_out,
    input logic              write_en,
    input logic              write_start,
    input logic [2:0]        op_mode
);

    logic in_sec;
    assign in_sec = (rd_addr[ADDR_W-1 -: SECT_W] == busy_sector);

    AST_WR_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || we_n || !oe_n || lockout) |-> !write_en); // R11

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        write_start |=> !write_start); // R12

    AST_START_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        write_start |-> write_en); // R12

    AST_LOCK_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> (op_mode == 3'(OPM_READ))); // R13

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        op_mode <= 3'(OPM_SUSP_PG)); // R2

    AST_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'(OPM_READ)) |-> (dq_out == array_data)); // R2

    AST_PROG_BIT2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'(OPM_PROG)) |-> dq_out[TOG2_BIT]); // R3

    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'(OPM_ERASE) && in_sec) |-> !dq_out[POLL_BIT]); // R4

    AST_SUSP_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (op_mode == 3'(OPM_SUSP_RD) && in_sec) |-> (dq_out[POLL_BIT] && dq_out[TOG6_BIT])); // R6

endmodule

bind flash_status_reporter fsr_checker #(
    .ADDR_W (ADDR_W),
    .SECT_W (SECT_W)
) u_fsr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lockout     (lockout),
    .ce_n        (ce_n),
    .we_n        (we_n),
    .oe_n        (oe_n),
    .rd_addr     (rd_addr),
    .busy_sector (busy_sector),
    .array_data  (array_data),
    .dq_out      (dq_out),
    .write_en    (write_en),
    .write_start (write_start),
    .op_mode     (op_mode)
);

// File: tb/test_flash_status_reporter.sv
module test_flash_status_reporter;

    localparam int ADDR_W = 19;
    localparam int SECT_W = 3;
    localparam int LOW_W  = ADDR_W - SECT_W;
    localparam logic [SECT_W-1:0] BUSY = 3'd5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lockout = 1'b0;
    logic              ce_n = 1'b1;
    logic              we_n = 1'b1;
    logic              oe_n = 1'b1;
    logic [2:0]        mode_sel = 3'd0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [SECT_W-1:0] busy_sector = BUSY;
    logic [ADDR_W-1:0] prog_addr = '0;
    logic              prog_data_b7 = 1'b0;
    logic [7:0]        array_data = 8'h00;
    logic [7:0]        dq_out;
    logic              write_en;
    logic              write_start;
    logic [2:0]        op_mode;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [2:0] m_mode = 3'd0;
    logic       m_t6 = 1'b0;
    logic       m_t2 = 1'b0;

    always #4 clk = ~clk;

    flash_status_reporter #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W)
    ) i_flash_status_reporter (
        .clk          (clk),
        .rst_n        (rst_n),
        .lockout      (lockout),
        .ce_n         (ce_n),
        .we_n         (we_n),
        .oe_n         (oe_n),
        .mode_sel     (mode_sel),
        .rd_addr      (rd_addr),
        .busy_sector  (busy_sector),
        .prog_addr    (prog_addr),
        .prog_data_b7 (prog_data_b7),
        .array_data   (array_data),
        .dq_out       (dq_out),
        .write_en     (write_en),
        .write_start  (write_start),
        .op_mode      (op_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] eff_mode(input logic [2:0] code, input logic lk);
        if (lk || code > 3'd4) return 3'd0;
        return code;
    endfunction

    function automatic logic [7:0] f_exp(input logic [2:0] md, input logic [ADDR_W-1:0] a,
                                         input logic [7:0] ad, input logic t6, input logic t2,
                                         output logic fl6, output logic fl2);
        logic sec, pa;
        sec = (a[ADDR_W-1 -: SECT_W] == BUSY);
        pa  = (a == prog_addr);
        fl6 = 1'b0;
        fl2 = 1'b0;
        if (md == 3'd1 || (md == 3'd4 && pa)) begin
            fl6 = 1'b1;
            return {~prog_data_b7, t6, 3'b000, 1'b1, 2'b00};
        end
        if (md == 3'd2 && sec) begin
            fl6 = 1'b1;
            fl2 = 1'b1;
            return {1'b0, t6, 3'b000, t2, 2'b00};
        end
        if ((md == 3'd3 || md == 3'd4) && sec) begin
            fl2 = 1'b1;
            return {1'b1, 1'b1, 3'b000, t2, 2'b00};
        end
        return ad;
    endfunction

    task automatic set_ctrl(input logic [2:0] code, input logic lk, input string tag);
        logic [2:0] e;
        @(negedge clk);
        mode_sel = code;
        lockout  = lk;
        @(negedge clk);
        e = eff_mode(code, lk);
        if (e != m_mode) begin
            m_t6 = 1'b0;
            m_t2 = 1'b0;
        end
        m_mode = e;
        check(tag, 32'(op_mode), 32'(e));
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input string tag);
        logic [7:0] ad;
        logic [7:0] e;
        logic f6, f2;
        @(negedge clk);
        rd_addr    = a;
        ad         = 8'($urandom);
        array_data = ad;
        ce_n       = 1'b0;
        oe_n       = 1'b0;
        we_n       = 1'b1;
        @(negedge clk);
        e = f_exp(m_mode, a, ad, m_t6, m_t2, f6, f2);
        check(tag, 32'(dq_out), 32'(e));
        oe_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
        if (f6) m_t6 = ~m_t6;
        if (f2) m_t2 = ~m_t2;
    endtask

    function automatic logic [ADDR_W-1:0] in_sec_addr();
        return {BUSY, LOW_W'($urandom)};
    endfunction

    function automatic logic [ADDR_W-1:0] out_sec_addr();
        return {3'd1, LOW_W'($urandom)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        prog_addr    = {3'd2, LOW_W'($urandom)};
        prog_data_b7 = 1'b1;
        array_data   = 8'hA5;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 op_mode", 32'(op_mode), 0);
        check("R1 dq", 32'(dq_out), 32'h A5);
        check("R1 write_en", 32'(write_en), 0);

        // R2 read mode and illegal codes
        do_read(in_sec_addr(), "R2 read");
        do_read(prog_addr, "R2 read");
        set_ctrl(3'd6, 1'b0, "R2 code6");
        do_read(in_sec_addr(), "R2 code6 read");

        // R3 program, R9 first read shows 0
        set_ctrl(3'd1, 1'b0, "R9 prog entry");
        for (int i = 0; i < 4; i++) do_read(out_sec_addr(), "R3 prog");
        prog_data_b7 = 1'b0;
        do_read(in_sec_addr(), "R3 prog b7");

        // R4 / R5 erase
        set_ctrl(3'd2, 1'b0, "R9 erase entry");
        do_read(in_sec_addr(), "R4 erase");
        do_read(in_sec_addr(), "R4 erase");
        do_read(out_sec_addr(), "R5 erase outside");
        do_read(in_sec_addr(), "R5 erase resume");
        // R10 rising oe with ce high
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk); oe_n = 1'b1;
        @(negedge clk);
        do_read(in_sec_addr(), "R10 ce high no step");

        // R6 / R7 suspended read
        set_ctrl(3'd3, 1'b0, "R9 susp rd entry");
        do_read(in_sec_addr(), "R6 susp rd");
        do_read(in_sec_addr(), "R6 susp rd");
        do_read(out_sec_addr(), "R7 susp rd outside");
        do_read(in_sec_addr(), "R6 susp rd");

        // R8 suspended program
        set_ctrl(3'd4, 1'b0, "R9 susp pg entry");
        do_read(prog_addr, "R8 at prog");
        do_read(prog_addr, "R8 at prog");
        do_read(in_sec_addr(), "R8 susp sector");
        do_read(out_sec_addr(), "R8 other");
        do_read(prog_addr, "R8 at prog");

        // R13 lockout in erase
        set_ctrl(3'd2, 1'b0, "R9 erase entry");
        do_read(in_sec_addr(), "R4 erase");
        set_ctrl(3'd2, 1'b1, "R13 lock forces read");
        do_read(in_sec_addr(), "R13 locked read");
        set_ctrl(3'd2, 1'b0, "R13 release");
        do_read(in_sec_addr(), "R13 toggles restart");

        // R11 / R12 write qualification
        set_ctrl(3'd0, 1'b0, "R2 back to read");
        for (int c = 0; c < 16; c++) begin
            logic e;
            @(negedge clk);
            ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lockout = 1'b0;
            @(negedge clk);
            ce_n = c[0]; we_n = c[1]; oe_n = c[2]; lockout = c[3];
            e = !c[0] && !c[1] && c[2] && !c[3];
            #1;
            check("R11 write_en", 32'(write_en), 32'(e));
            check("R12 start", 32'(write_start), 32'(e));
            @(negedge clk);
            check("R12 one pulse", 32'(write_start), 0);
            check("R11 held", 32'(write_en), 32'(e));
        end
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lockout = 1'b0;
        @(negedge clk);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 8);
            if (r == 0) begin
                set_ctrl(3'($urandom), ($urandom % 6) == 0, "R9 R13 random mode");
            end else if (r < 4) begin
                do_read(in_sec_addr(), "R4 R6 random sector");
            end else if (r < 6) begin
                do_read(prog_addr, "R3 R8 random prog");
            end else begin
                do_read(ADDR_W'($urandom), "R5 R7 random addr");
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule